// File: doc/BRIEF.md
# Filter Output Destination Router

This block sits at the output of one channel's filter compute engine. It steers every finished I/Q result to the places named by an 11-bit destination field carried with the filter instruction that made it. The places are:

- a recirculation path back into the engine input, for cascaded filtering;
- the write port of the sample-spacing FIFO that feeds the AGC multipliers;
- the direct cascade outputs.

The same field can raise an AGC loop update with a gain-select bit, start serial output, and feed the converter's magnitude and phase derivative back into the engine in place of new data. The magnitude and phase-derivative feedback supports AM and FM filtering.

The block also owns the engine input selector, which has three sources: new decimated data, recirculated results and magnitude/phase feedback. The FIFO, AGC arithmetic, cartesian-to-polar converter and serial shifter live outside the block. The FIFO write port carries a tag that tells the downstream AGC output stage whether the sample leaves on the main pair (I1/Q1) or the cascade pair (I2/Q2). Every output is registered, so each one appears exactly one clock after the input that caused it.

Top module: `fod_router`

## Requirements
- R1: During and right after reset, all strobes (`eng_valid`, `fifo_wr`, `cas_valid`, `agc_upd`, `ser_start`) are low, `eng_src` is 0, and every data, step, tag and gain-select output is zero.
- R2: A valid result whose path code (destination bits 8:7) is 00, and whose feedback bit is clear, appears on the engine input one clock later. In that cycle `eng_src` = 2 and `eng_i`/`eng_q` equal the result.
- R3: Path code 01 writes the result into the FIFO one clock later (`fifo_wr` high, `fifo_to_cas` = 0, data equal to the result).
- R4: Path code 10 raises `cas_valid` one clock later with the result on `cas_i`/`cas_q`, and does not write the FIFO.
- R5: Path code 11 writes the FIFO one clock later with `fifo_to_cas` = 1, and does not raise `cas_valid`.
- R6: `agc_upd` pulses one clock after a valid result that has path code 01 and update bit (bit 9) set. In that case `agc_gsel` takes the gain-select bit (bit 10). With any other path code, both bits are ignored: no pulse is raised and `agc_gsel` keeps its value.
- R7: `ser_start` pulses one clock after a valid result whose strobe bit (bit 6) is set.
- R8: A valid result with the feedback bit (bit 5) set gives `eng_src` = 3 one clock later. `eng_i` then carries `mag_in`. `eng_q` carries `dphi_in` (signed) multiplied by 1, 2, 4 or 8 for `dphi_scale` 0, 1, 2 or 3, saturated to the signed data range.
- R9: The engine input source priority is magnitude/phase feedback first, then recirculation, then new data. `eng_src` = 1 with the new sample only when neither of the other two is requested. `eng_src` = 0 and `eng_valid` low when nothing is requested.
- R10: The step number (bits 4:0) of a routed result is passed through unchanged on `fifo_step`, `cas_step` or `eng_step` with its sample. `eng_step` is not changed by new data.
- R11: A data output (engine, FIFO or cascade) keeps its last value in every cycle in which its own strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Filter result valid |
| res_i | input | DATA_W | Result I |
| res_q | input | DATA_W | Result Q |
| res_dest | input | 11 | Destination field of the producing instruction |
| new_valid | input | 1 | New decimated sample available |
| new_i | input | DATA_W | New sample I |
| new_q | input | DATA_W | New sample Q |
| mag_in | input | DATA_W | Magnitude from the converter |
| dphi_in | input | DATA_W | Phase derivative from the converter (signed) |
| dphi_scale | input | 2 | Phase-derivative gain code (x1, x2, x4, x8) |
| eng_valid | output | 1 | Engine input sample valid |
| eng_src | output | 2 | Engine source: 0 none, 1 new, 2 recirc, 3 mag/phase |
| eng_i | output | DATA_W | Engine input I |
| eng_q | output | DATA_W | Engine input Q |
| eng_step | output | 5 | Step number of a fed-back result |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_to_cas | output | 1 | FIFO sample exits on the cascade pair |
| fifo_i | output | DATA_W | FIFO write data I |
| fifo_q | output | DATA_W | FIFO write data Q |
| fifo_step | output | 5 | Step number with the FIFO sample |
| cas_valid | output | 1 | Direct cascade output valid |
| cas_i | output | DATA_W | Cascade I |
| cas_q | output | DATA_W | Cascade Q |
| cas_step | output | 5 | Step number with the cascade sample |
| agc_upd | output | 1 | AGC loop update pulse |
| agc_gsel | output | 1 | AGC loop gain select |
| ser_start | output | 1 | Start serial output with this sample |

## Verification
The assertions assume that the inputs are stable and known at each rising edge while reset is high. They also assume that `res_dest` means something only in a cycle where `res_valid` is high, and that `mag_in` and `dphi_in` are current whenever the feedback bit is set. The stimulus changes all inputs only on the falling clock edge. It draws destination fields, with every path code, feedback and strobe combination, from a seeded random source. It randomises the other fields freely on cycles where `res_valid` is low, so that the ignore rules are exercised. Directed cycles add the saturation extremes of `dphi_in`, AGC bits on the wrong paths, and feedback colliding with recirculation and new data.

// File: rtl/fod_pkg.sv
package fod_pkg;
  localparam int DEST_W = 11;
  localparam int STEP_W = 5;

  typedef enum logic [1:0] {
    PATH_RECIRC   = 2'b00,
    PATH_AGC_MAIN = 2'b01,
    PATH_DIRECT   = 2'b10,
    PATH_AGC_CAS  = 2'b11
  } path_e;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_NEW    = 2'd1,
    SRC_RECIRC = 2'd2,
    SRC_MAGPH  = 2'd3
  } src_e;

  // Field layout, most significant first; the bit positions are decoded.
  typedef struct packed {
    logic              gain_sel;  // bit 10
    logic              agc_upd;   // bit 9
    path_e             path;      // bits 8:7
    logic              strobe;    // bit 6
    logic              fb;        // bit 5
    logic [STEP_W-1:0] step;      // bits 4:0
  } dest_t;
endpackage

// File: rtl/fod_decode.sv
module fod_decode
  import fod_pkg::*;
(
  input  logic              valid,
  input  logic [DEST_W-1:0] dest,
  output logic              rec_req,
  output logic              fb_req,
  output logic              fifo_req,
  output logic              fifo_cas,
  output logic              cas_req,
  output logic              agc_fire,
  output logic              gsel,
  output logic              ser_fire,
  output logic [STEP_W-1:0] step
);
  dest_t d;
  assign d = dest_t'(dest);

  always_comb begin
    rec_req  = 1'b0;
    fifo_req = 1'b0;
    fifo_cas = 1'b0;
    cas_req  = 1'b0;
    agc_fire = 1'b0;
    if (valid) begin
      unique case (d.path)
        PATH_RECIRC:   rec_req = 1'b1;
        PATH_AGC_MAIN: begin
          fifo_req = 1'b1;
          agc_fire = d.agc_upd;
        end
        PATH_DIRECT:   cas_req = 1'b1;
        PATH_AGC_CAS:  begin
          fifo_req = 1'b1;
          fifo_cas = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign gsel     = d.gain_sel;
  assign fb_req   = valid && d.fb;
  assign ser_fire = valid && d.strobe;
  assign step     = d.step;

  always_comb begin
    if (valid) begin
      a_r5_one_path: assert ($countones({rec_req, fifo_req, cas_req}) == 1);
    end
  end
endmodule

// File: rtl/fod_engine_mux.sv
module fod_engine_mux
  import fod_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              new_valid,
  input  logic [W-1:0]      new_i,
  input  logic [W-1:0]      new_q,
  input  logic              rec_req,
  input  logic [W-1:0]      rec_i,
  input  logic [W-1:0]      rec_q,
  input  logic              fb_req,
  input  logic [W-1:0]      mag_in,
  input  logic [W-1:0]      dphi_in,
  input  logic [1:0]        dphi_scale,
  input  logic [STEP_W-1:0] step_in,
  output logic              eng_valid,
  output logic [1:0]        eng_src,
  output logic [W-1:0]      eng_i,
  output logic [W-1:0]      eng_q,
  output logic [STEP_W-1:0] eng_step
);
  localparam int WX = W + 3;

  // Signed shift by 0..3 with clamping to the W-bit signed range.
  function automatic logic [W-1:0] sat_scale(input logic [W-1:0] v, input logic [1:0] k);
    logic signed [WX-1:0] wide;
    logic signed [WX-1:0] hi;
    logic signed [WX-1:0] lo;
    wide = signed'({{3{v[W-1]}}, v}) <<< k;
    hi   = signed'({4'b0000, {(W-1){1'b1}}});
    lo   = signed'({4'b1111, {(W-1){1'b0}}});
    if (wide > hi)      return hi[W-1:0];
    else if (wide < lo) return lo[W-1:0];
    else                return wide[W-1:0];
  endfunction

  src_e         sel_c;
  src_e         src_q;
  logic [W-1:0] dat_i_c;
  logic [W-1:0] dat_q_c;
  logic [W-1:0] dphi_scaled;

  assign dphi_scaled = sat_scale(dphi_in, dphi_scale);

  always_comb begin
    if (fb_req) begin
      sel_c   = SRC_MAGPH;
      dat_i_c = mag_in;
      dat_q_c = dphi_scaled;
    end else if (rec_req) begin
      sel_c   = SRC_RECIRC;
      dat_i_c = rec_i;
      dat_q_c = rec_q;
    end else if (new_valid) begin
      sel_c   = SRC_NEW;
      dat_i_c = new_i;
      dat_q_c = new_q;
    end else begin
      sel_c   = SRC_NONE;
      dat_i_c = '0;
      dat_q_c = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= SRC_NONE;
      eng_i    <= '0;
      eng_q    <= '0;
      eng_step <= '0;
    end else begin
      src_q <= sel_c;
      if (sel_c != SRC_NONE) begin
        eng_i <= dat_i_c;
        eng_q <= dat_q_c;
      end
      if (fb_req || rec_req) eng_step <= step_in;
    end
  end

  assign eng_src   = src_q;
  assign eng_valid = (src_q != SRC_NONE);

  a_r9_feedback_first: assert property (@(posedge clk) disable iff (!rst_n)
    fb_req |=> (eng_src == SRC_MAGPH));
  a_r9_recirc_over_new: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_req && !fb_req) |=> (eng_src == SRC_RECIRC));
  a_r9_new_only_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_src == SRC_NEW) |-> $past(new_valid && !fb_req && !rec_req));
  a_r8_mag_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_src == SRC_MAGPH) |-> (eng_i == $past(mag_in)));
  a_r11_engine_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_valid |-> ($stable(eng_i) && $stable(eng_q)));
endmodule

// File: rtl/fod_out_stage.sv
module fod_out_stage
  import fod_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [W-1:0]      d_i,
  input  logic [W-1:0]      d_q,
  input  logic [STEP_W-1:0] d_step,
  output logic              vld,
  output logic [W-1:0]      q_i,
  output logic [W-1:0]      q_q,
  output logic [STEP_W-1:0] q_step
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= 1'b0;
      q_i    <= '0;
      q_q    <= '0;
      q_step <= '0;
    end else begin
      vld <= ld;
      if (ld) begin
        q_i    <= d_i;
        q_q    <= d_q;
        q_step <= d_step;
      end
    end
  end

  a_r11_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> ($stable(q_i) && $stable(q_q) && $stable(q_step)));
  a_r10_step_follows: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (q_step == $past(d_step)));
endmodule

// File: rtl/fod_router.sv
module fod_router
  import fod_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_i,
  input  logic [DATA_W-1:0] res_q,
  input  logic [10:0]       res_dest,
  input  logic              new_valid,
  input  logic [DATA_W-1:0] new_i,
  input  logic [DATA_W-1:0] new_q,
  input  logic [DATA_W-1:0] mag_in,
  input  logic [DATA_W-1:0] dphi_in,
  input  logic [1:0]        dphi_scale,
  output logic              eng_valid,
  output logic [1:0]        eng_src,
  output logic [DATA_W-1:0] eng_i,
  output logic [DATA_W-1:0] eng_q,
  output logic [4:0]        eng_step,
  output logic              fifo_wr,
  output logic              fifo_to_cas,
  output logic [DATA_W-1:0] fifo_i,
  output logic [DATA_W-1:0] fifo_q,
  output logic [4:0]        fifo_step,
  output logic              cas_valid,
  output logic [DATA_W-1:0] cas_i,
  output logic [DATA_W-1:0] cas_q,
  output logic [4:0]        cas_step
  ,
  output logic              agc_upd,
  output logic              agc_gsel,
  output logic              ser_start
);
  localparam int LANES = 2;  // lane 0: FIFO write, lane 1: direct cascade

  // Decoded routing events, named for the assertions.
  logic              ev_rec, ev_fb, ev_fifo, ev_fifo_cas, ev_cas;
  logic              ev_agc, ev_gsel, ev_ser;
  logic [STEP_W-1:0] ev_step;

  fod_decode u_dec (
    .valid    (res_valid),
    .dest     (res_dest),
    .rec_req  (ev_rec),
    .fb_req   (ev_fb),
    .fifo_req (ev_fifo),
    .fifo_cas (ev_fifo_cas),
    .cas_req  (ev_cas),
    .agc_fire (ev_agc),
    .gsel     (ev_gsel),
    .ser_fire (ev_ser),
    .step     (ev_step)
  );

  fod_engine_mux #(.W(DATA_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .new_valid  (new_valid),
    .new_i      (new_i),
    .new_q      (new_q),
    .rec_req    (ev_rec),
    .rec_i      (res_i),
    .rec_q      (res_q),
    .fb_req     (ev_fb),
    .mag_in     (mag_in),
    .dphi_in    (dphi_in),
    .dphi_scale (dphi_scale),
    .step_in    (ev_step),
    .eng_valid  (eng_valid),
    .eng_src    (eng_src),
    .eng_i      (eng_i),
    .eng_q      (eng_q),
    .eng_step   (eng_step)
  );

  logic [LANES-1:0]             lane_ld;
  logic [LANES-1:0]             lane_vld;
  logic [LANES-1:0][DATA_W-1:0] lane_i;
  logic [LANES-1:0][DATA_W-1:0] lane_q;
  logic [LANES-1:0][STEP_W-1:0] lane_step;

  assign lane_ld = {ev_cas, ev_fifo};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fod_out_stage #(.W(DATA_W)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (lane_ld[g]),
      .d_i    (res_i),
      .d_q    (res_q),
      .d_step (ev_step),
      .vld    (lane_vld[g]),
      .q_i    (lane_i[g]),
      .q_q    (lane_q[g]),
      .q_step (lane_step[g])
    );
  end

  assign fifo_wr   = lane_vld[0];
  assign fifo_i    = lane_i[0];
  assign fifo_q    = lane_q[0];
  assign fifo_step = lane_step[0];
  assign cas_valid = lane_vld[1];
  assign cas_i     = lane_i[1];
  assign cas_q     = lane_q[1];
  assign cas_step  = lane_step[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_to_cas <= 1'b0;
      agc_upd     <= 1'b0;
      agc_gsel    <= 1'b0;
      ser_start   <= 1'b0;
    end else begin
      agc_upd   <= ev_agc;
      ser_start <= ev_ser;
      if (ev_fifo) fifo_to_cas <= ev_fifo_cas;
      if (ev_agc)  agc_gsel    <= ev_gsel;
    end
  end

  a_r6_agc_path01_only: assert property (@(posedge clk) disable iff (!rst_n)
    agc_upd |-> $past(res_valid && res_dest[8:7] == 2'b01 && res_dest[9]));
  a_r6_gsel_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !agc_upd |-> $stable(agc_gsel));
  a_r7_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
    ser_start |-> $past(res_valid && res_dest[6]));
  a_r4_direct_not_fifo: assert property (@(posedge clk) disable iff (!rst_n)
    !(cas_valid && fifo_wr));
  a_r3_fifo_data: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (fifo_i == $past(res_i) && fifo_q == $past(res_q)));
endmodule

// File: tb/fod_router_test.sv
module fod_router_test;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          res_valid = 1'b0;
  logic [W-1:0]  res_i = '0, res_q = '0;
  logic [10:0]   res_dest = '0;
  logic          new_valid = 1'b0;
  logic [W-1:0]  new_i = '0, new_q = '0, mag_in = '0, dphi_in = '0;
  logic [1:0]    dphi_scale = '0;
  logic          eng_valid, fifo_wr, fifo_to_cas, cas_valid, agc_upd, agc_gsel, ser_start;
  logic [1:0]    eng_src;
  logic [W-1:0]  eng_i, eng_q, fifo_i, fifo_q, cas_i, cas_q;
  logic [4:0]    eng_step, fifo_step, cas_step;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected state
  logic          x_eng_v, x_fifo_wr, x_fifo_cas, x_cas_v, x_agc, x_gsel, x_ser;
  logic [1:0]    x_src;
  logic [W-1:0]  x_eng_i, x_eng_q, x_fifo_i, x_fifo_q, x_cas_i, x_cas_q;
  logic [4:0]    x_eng_step, x_fifo_step, x_cas_step;

  always #4 clk = ~clk;

  fod_router #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_i(res_i), .res_q(res_q),
    .res_dest(res_dest), .new_valid(new_valid), .new_i(new_i), .new_q(new_q),
    .mag_in(mag_in), .dphi_in(dphi_in), .dphi_scale(dphi_scale),
    .eng_valid(eng_valid), .eng_src(eng_src), .eng_i(eng_i), .eng_q(eng_q),
    .eng_step(eng_step), .fifo_wr(fifo_wr), .fifo_to_cas(fifo_to_cas),
    .fifo_i(fifo_i), .fifo_q(fifo_q), .fifo_step(fifo_step),
    .cas_valid(cas_valid), .cas_i(cas_i), .cas_q(cas_q), .cas_step(cas_step),
    .agc_upd(agc_upd), .agc_gsel(agc_gsel), .ser_start(ser_start)
  );

  function automatic logic [10:0] mk_dest(bit gs, bit up, bit [1:0] p, bit st, bit fb,
                                          bit [4:0] sn);
    return {gs, up, p, st, fb, sn};
  endfunction

  // x1/x2/x4/x8 gain on a signed value, clamped to W-bit signed range
  function automatic logic [W-1:0] exp_scale(logic [W-1:0] v, logic [1:0] k);
    longint s = longint'(signed'(v));
    longint m = 1;
    longint hi = (longint'(1) << (W - 1)) - 1;
    longint lo = -(longint'(1) << (W - 1));
    for (int n = 0; n < int'(k); n++) m = m * 2;
    s = s * m;
    if (s > hi) s = hi;
    if (s < lo) s = lo;
    return W'(s);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reset_model();
    {x_eng_v, x_fifo_wr, x_fifo_cas, x_cas_v, x_agc, x_gsel, x_ser} = '0;
    x_src = 2'd0;
    {x_eng_i, x_eng_q, x_fifo_i, x_fifo_q, x_cas_i, x_cas_q} = '0;
    {x_eng_step, x_fifo_step, x_cas_step} = '0;
  endtask

  // Model of one clock edge, from the requirements.
  task automatic predict();
    logic [1:0] p = res_dest[8:7];
    bit fb = res_valid && res_dest[5];
    bit rc = res_valid && (p == 2'b00);
    x_fifo_wr = res_valid && p[0];                 // R3, R5: 01 and 11
    x_cas_v   = res_valid && (p == 2'b10);         // R4
    if (x_fifo_wr) begin
      x_fifo_i = res_i; x_fifo_q = res_q; x_fifo_step = res_dest[4:0];
      x_fifo_cas = p[1];
    end
    if (x_cas_v) begin
      x_cas_i = res_i; x_cas_q = res_q; x_cas_step = res_dest[4:0];
    end
    x_agc = res_valid && (p == 2'b01) && res_dest[9];   // R6
    if (x_agc) x_gsel = res_dest[10];
    x_ser = res_valid && res_dest[6];                   // R7
    if (fb) begin                                       // R8, R9
      x_src = 2'd3; x_eng_i = mag_in; x_eng_q = exp_scale(dphi_in, dphi_scale);
    end else if (rc) begin                              // R2
      x_src = 2'd2; x_eng_i = res_i; x_eng_q = res_q;
    end else if (new_valid) begin
      x_src = 2'd1; x_eng_i = new_i; x_eng_q = new_q;
    end else begin
      x_src = 2'd0;
    end
    if (fb || rc) x_eng_step = res_dest[4:0];           // R10
    x_eng_v = (x_src != 2'd0);
  endtask

  task automatic compare();
    string et = (x_src == 2'd3) ? "R8" : (x_src == 2'd2) ? "R2" : "R9";
    string ft = x_fifo_wr ? (x_fifo_cas ? "R5" : "R3") : "R11";
    string ct = x_cas_v ? "R4" : "R11";
    chk("R9", "eng_src", 32'(eng_src), 32'(x_src));
    chk("R9", "eng_valid", 32'(eng_valid), 32'(x_eng_v));
    chk(x_eng_v ? et : "R11", "eng_i", 32'(eng_i), 32'(x_eng_i));
    chk(x_eng_v ? et : "R11", "eng_q", 32'(eng_q), 32'(x_eng_q));
    chk("R10", "eng_step", 32'(eng_step), 32'(x_eng_step));
    chk(ft, "fifo_wr", 32'(fifo_wr), 32'(x_fifo_wr));
    chk(ft, "fifo_to_cas", 32'(fifo_to_cas), 32'(x_fifo_cas));
    chk(ft, "fifo_i", 32'(fifo_i), 32'(x_fifo_i));
    chk(ft, "fifo_q", 32'(fifo_q), 32'(x_fifo_q));
    chk("R10", "fifo_step", 32'(fifo_step), 32'(x_fifo_step));
    chk(ct, "cas_valid", 32'(cas_valid), 32'(x_cas_v));
    chk(ct, "cas_i", 32'(cas_i), 32'(x_cas_i));
    chk(ct, "cas_q", 32'(cas_q), 32'(x_cas_q));
    chk("R10", "cas_step", 32'(cas_step), 32'(x_cas_step));
    chk("R6", "agc_upd", 32'(agc_upd), 32'(x_agc));
    chk("R6", "agc_gsel", 32'(agc_gsel), 32'(x_gsel));
    chk("R7", "ser_start", 32'(ser_start), 32'(x_ser));
  endtask

  // Drive one cycle at the falling edge, check at the next falling edge.
  task automatic cyc(bit v, logic [W-1:0] ri, logic [W-1:0] rq, logic [10:0] d,
                     bit nv, logic [W-1:0] ni, logic [W-1:0] nq,
                     logic [W-1:0] mg, logic [W-1:0] dp, logic [1:0] sc);
    res_valid = v; res_i = ri; res_q = rq; res_dest = d;
    new_valid = nv; new_i = ni; new_q = nq; mag_in = mg; dphi_in = dp; dphi_scale = sc;
    predict();
    @(negedge clk);
    compare();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    reset_model();
    repeat (3) @(negedge clk);
    compare();  // R1 reset state while reset is held
    rst_n = 1'b1;
    @(negedge clk);
    compare();  // R1 first cycle after reset

    // Directed corner cases
    cyc(1, 16'h1111, 16'h2222, mk_dest(1, 1, 2'b01, 0, 0, 5'd1), 0, 0, 0, 0, 0, 0); // R3 R6
    cyc(0, 16'hdead, 16'hbeef, mk_dest(0, 1, 2'b01, 1, 1, 5'd9), 0, 0, 0, 0, 0, 0); // R11 idle
    cyc(1, 16'h3333, 16'h4444, mk_dest(0, 1, 2'b11, 1, 0, 5'd2), 0, 0, 0, 0, 0, 0); // R5 R6 R7
    cyc(1, 16'h5555, 16'h6666, mk_dest(0, 1, 2'b10, 0, 0, 5'd3), 1, 16'h7, 16'h8, 0, 0, 0); // R4 R9
    cyc(1, 16'h0a0a, 16'h0b0b, mk_dest(0, 0, 2'b00, 0, 0, 5'd4), 1, 16'h9, 16'ha, 0, 0, 0); // R2 R9
    cyc(1, 16'h0c0c, 16'h0d0d, mk_dest(0, 0, 2'b00, 0, 1, 5'd5), 1, 16'hb, 16'hc,
        16'h1234, 16'h4000, 2'd3);                                                       // R8 sat hi
    cyc(1, 16'h0e0e, 16'h0f0f, mk_dest(0, 0, 2'b10, 0, 1, 5'd6), 0, 0, 0,
        16'h0042, 16'h8000, 2'd1);                                                       // R8 sat lo
    cyc(1, 0, 0, mk_dest(0, 0, 2'b01, 0, 1, 5'd7), 0, 0, 0, 16'h0001, 16'hfffd, 2'd2);   // R8 -3*4
    cyc(0, 0, 0, 0, 1, 16'h1357, 16'h2468, 0, 0, 0);                                     // R9 R10 new
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);                                                   // R9 none

    // Seeded random traffic
    for (int n = 0; n < 3000; n++) begin
      bit v  = ($urandom_range(0, 9) < 6);
      bit fb = ($urandom_range(0, 7) == 0);
      logic [10:0] d = 11'($urandom);
      logic [W-1:0] dp = ($urandom_range(0, 5) == 0) ? W'({1'b0, {(W-1){1'b1}}}) : W'($urandom);
      d[5] = fb;
      cyc(v, W'($urandom), W'($urandom), d, ($urandom_range(0, 1) == 1),
          W'($urandom), W'($urandom), W'($urandom), dp, 2'($urandom));
    end
    finish_run();
  end
endmodule